// File: doc/BRIEF.md
# Key slot permission gate

This block guards a bank of key slots. Each slot keeps a 32-bit destination address, a 32-bit permission word and a 128-bit key split into four 32-bit words. Software reaches the slots over a simple word-addressed register bus. A slot's registers answer only while a select register in the block's control space names that slot, counted from one. On every access the block checks the slot's permission word to decide whether a key read or key write may go ahead. Refused accesses return zero and raise an error flag.

A push command moves the selected slot's key out on a secure write port without exposing it to software. The block sends the four key words one per cycle, word 0 first, to consecutive addresses starting at the slot's stored destination. The permission word has two 16-bit halves that are each write-once: a half can be written only while it still reads all ones. Its state bit revokes a key for good, which blocks both reading and pushing it. All storage starts as all ones, the erased state.

Top module: `key_slot_gate`

## Requirements
- R1: After reset every destination, permission and key word reads 0xFFFFFFFF, the select register reads 0, and pushBusy, secValid, pushDone and pushErr are low.
- R2: regAddr bit 10 set selects slot space, with the slot number n in bits 9:3 and the word in bits 2:0 (0 destination, 1 permission, 2..5 key words 0..3). In slot space, words 6 and 7 give an error. With bit 10 clear, word 0 is the select register and a write to word 1 is a push command. Other control words read 0 and never raise an error. regRspValid, regRData and regAccErr appear in the cycle after the request.
- R3: A slot-space access to slot n is accepted only while the select register holds n+1. Any other select value, including 0 and values above the slot count, makes a read return 0 with regAccErr set and drops a write with regAccErr set.
- R4: A write to the permission word updates its low half (bits 15:0) only if that half reads 0xFFFF, and its high half (bits 31:16) only if that half reads 0xFFFF. A locked half keeps its value, and the write raises no error.
- R5: Permission bit 16 is the active state (1 active, 0 revoked). Once it is 0, writing 1 to it has no effect, key reads are refused and pushes are denied.
- R6: A key word read is allowed only when permission bit 1 (read) and bit 16 are both 1. Otherwise it returns 0 with regAccErr set. A cleared push bit (bit 2) does not block reads.
- R7: A key word write is allowed only when permission bit 0 (write) is 1. Otherwise it is dropped and regAccErr is set.
- R8: The destination word of the selected slot can be read and written with no permission check.
- R9: An accepted push (valid select, permission bits 2 and 16 set) raises pushBusy and secValid for the four cycles after the command. In cycle i (i = 0..3) secAddr is destination + 4*i and secData is key word i. pushDone then pulses for one cycle with pushErr low.
- R10: A push with no valid slot selected, push bit 2 clear, or the slot revoked is denied. pushDone and pushErr pulse together in the cycle after the command, and secValid stays low.
- R11: A push command that arrives while pushBusy is high is ignored. It does not disturb the running sequence and does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 write, 0 read |
| regAddr | input | 11 | Word address (space, slot, word) |
| regWData | input | 32 | Write data |
| regRspValid | output | 1 | Response for the previous cycle's request |
| regRData | output | 32 | Read data, 0 for refused reads |
| regAccErr | output | 1 | Access refused |
| pushBusy | output | 1 | Push sequence running |
| pushDone | output | 1 | One-cycle pulse when a push ends or is denied |
| pushErr | output | 1 | Push was denied (valid with pushDone) |
| secValid | output | 1 | Secure write beat valid |
| secAddr | output | 32 | Secure write address |
| secData | output | 32 | Secure write data (key word) |

## Verification
The assertions check several rules on every cycle. Neither half of the permission word is written once it differs from all ones. A key write strobe never fires without write permission. A revoked slot stays revoked while it remains selected. Refused reads always return zero. Every push sequence ends with a clean done pulse, and a denied push never overlaps a secure write beat. Only the bench's scenarios can show whether the right data and address leave on each beat, in word order. The same holds for the select register steering accesses to the right slot, and for a second push command during a running sequence leaving the beats untouched.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  localparam int KEY_WORDS = 4;
  localparam int WORD_DEST = 0;
  localparam int WORD_PERM = 1;
  localparam int WORD_KEY0 = 2;
  localparam int CTL_SEL = 0;
  localparam int CTL_PUSH = 1;
  localparam int BIT_WR = 0;
  localparam int BIT_RD = 1;
  localparam int BIT_PUSH = 2;
  localparam int BIT_ACTIVE = 16;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_DEST, RD_PERM, RD_KEY
  } rdSrc_e;

  typedef struct packed {
    logic selWe;
    logic destWe;
    logic permWeLo;
    logic permWeHi;
    logic keyWe;
    logic [1:0] keyWord;
    rdSrc_e rdSrc;
  } strobe_t;
endpackage

// File: rtl/ksg_datapath.sv
module ksg_datapath
  import ksg_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int SEL_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       wData,
  input  logic [SLOT_W-1:0] pushSlot,
  input  logic [1:0]        pushWord,
  output logic [SEL_W-1:0]  selValue,
  output logic [31:0]       selPerm,
  output logic [31:0]       rdData,
  output logic [31:0]       secAddr,
  output logic [31:0]       secData
);
  logic [SEL_W-1:0]  selReg;
  logic [SLOT_W-1:0] selIdx;
  logic [31:0] destMem [NUM_SLOTS];
  logic [31:0] permMem [NUM_SLOTS];
  logic [31:0] keyMem  [NUM_SLOTS][KEY_WORDS];

  assign selIdx   = SLOT_W'(selReg - 1'b1);
  assign selValue = selReg;
  assign selPerm  = permMem[selIdx];
  assign secAddr  = destMem[pushSlot] + {28'd0, pushWord, 2'b00};
  assign secData  = keyMem[pushSlot][pushWord];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      rdData <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        destMem[i] <= '1;
        permMem[i] <= '1;
        for (int k = 0; k < KEY_WORDS; k++) keyMem[i][k] <= '1;
      end
    end else begin
      if (stb.selWe) selReg <= wData[SEL_W-1:0];
      if (stb.destWe) destMem[selIdx] <= wData;
      if (stb.permWeLo) permMem[selIdx][15:0] <= wData[15:0];
      if (stb.permWeHi)
        permMem[selIdx][31:16] <= {wData[31:17], wData[BIT_ACTIVE] & permMem[selIdx][BIT_ACTIVE]};
      if (stb.keyWe) keyMem[selIdx][stb.keyWord] <= wData;
      case (stb.rdSrc)
        RD_SEL:  rdData <= 32'(selReg);
        RD_DEST: rdData <= destMem[selIdx];
        RD_PERM: rdData <= permMem[selIdx];
        RD_KEY:  rdData <= keyMem[selIdx][stb.keyWord];
        default: rdData <= '0;
      endcase
    end
  end

  // R4: a half is only written while it still reads all ones
  p_half_lock_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.permWeLo |-> selPerm[15:0] == 16'hFFFF);
  p_half_lock_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.permWeHi |-> selPerm[31:16] == 16'hFFFF);
  // R7: key store strobe only with write permission
  p_key_we_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.keyWe |-> selPerm[BIT_WR]);
  // R5: revocation sticks while the same slot stays selected
  p_revoke_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!selPerm[BIT_ACTIVE] && !stb.selWe) |=> !selPerm[BIT_ACTIVE]);
endmodule

// File: rtl/ksg_control.sv
module ksg_control
  import ksg_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int SEL_W = SLOT_W + 1,
  localparam int ADDR_W = SLOT_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SEL_W-1:0]  selValue,
  input  logic [31:0]       selPerm,
  output strobe_t           stb,
  output logic              rspValid,
  output logic              accErr,
  output logic [SLOT_W-1:0] pushSlot,
  output logic [1:0]        pushWord,
  output logic              pushBusy,
  output logic              pushDone,
  output logic              pushErr
);
  logic              slotSpace;
  logic [SLOT_W-1:0] addrSlot;
  logic [2:0]        word;
  logic              selOk;
  logic              hit;
  logic              errNext;
  logic              pushCmd;
  logic              pushOk;

  assign slotSpace = regAddr[ADDR_W-1];
  assign addrSlot  = regAddr[SLOT_W+2:3];
  assign word      = regAddr[2:0];
  assign selOk     = (selValue != '0) && (selValue <= SEL_W'(NUM_SLOTS));
  assign hit       = selOk && (addrSlot == SLOT_W'(selValue - 1'b1));
  assign pushOk    = selOk && selPerm[BIT_PUSH] && selPerm[BIT_ACTIVE];

  always_comb begin
    stb = '0;
    stb.rdSrc = RD_ZERO;
    errNext = 1'b0;
    pushCmd = 1'b0;
    if (regValid) begin
      if (!slotSpace) begin
        if (regWrite) begin
          stb.selWe = (word == 3'(CTL_SEL));
          pushCmd   = (word == 3'(CTL_PUSH));
        end else if (word == 3'(CTL_SEL)) begin
          stb.rdSrc = RD_SEL;
        end
      end else if (!hit || word > 3'd5) begin
        errNext = 1'b1;
      end else begin
        case (word)
          3'(WORD_DEST): begin
            if (regWrite) stb.destWe = 1'b1;
            else stb.rdSrc = RD_DEST;
          end
          3'(WORD_PERM): begin
            if (regWrite) begin
              stb.permWeLo = (selPerm[15:0] == 16'hFFFF);
              stb.permWeHi = (selPerm[31:16] == 16'hFFFF);
            end else begin
              stb.rdSrc = RD_PERM;
            end
          end
          default: begin
            stb.keyWord = 2'(word - 3'(WORD_KEY0));
            if (regWrite) begin
              if (selPerm[BIT_WR]) stb.keyWe = 1'b1;
              else errNext = 1'b1;
            end else if (selPerm[BIT_RD] && selPerm[BIT_ACTIVE]) begin
              stb.rdSrc = RD_KEY;
            end else begin
              errNext = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      accErr   <= 1'b0;
      pushSlot <= '0;
      pushWord <= '0;
      pushBusy <= 1'b0;
      pushDone <= 1'b0;
      pushErr  <= 1'b0;
    end else begin
      rspValid <= regValid;
      accErr   <= errNext;
      pushDone <= 1'b0;
      pushErr  <= 1'b0;
      if (pushBusy) begin
        if (pushWord == 2'd3) begin
          pushBusy <= 1'b0;
          pushDone <= 1'b1;
        end else begin
          pushWord <= pushWord + 2'd1;
        end
      end else if (pushCmd) begin
        if (pushOk) begin
          pushBusy <= 1'b1;
          pushWord <= 2'd0;
          pushSlot <= SLOT_W'(selValue - 1'b1);
        end else begin
          pushDone <= 1'b1;
          pushErr  <= 1'b1;
        end
      end
    end
  end

  // R9: every sequence ends with a clean completion pulse
  p_push_ends_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pushBusy) |-> (pushDone && !pushErr));
  // R10: a denial never overlaps a running sequence
  p_denied_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    pushErr |-> (pushDone && !pushBusy));
  // R11: once running, the sequence keeps its slot
  p_slot_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pushBusy && $past(pushBusy)) |-> $stable(pushSlot));
endmodule

// File: rtl/key_slot_gate.sv
module key_slot_gate
  import ksg_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int SEL_W = SLOT_W + 1,
  localparam int ADDR_W = SLOT_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic              regRspValid,
  output logic [31:0]       regRData,
  output logic              regAccErr,
  output logic              pushBusy,
  output logic              pushDone,
  output logic              pushErr,
  output logic              secValid,
  output logic [31:0]       secAddr,
  output logic [31:0]       secData
);
  strobe_t           stb;
  logic [SEL_W-1:0]  selValue;
  logic [31:0]       selPerm;
  logic [SLOT_W-1:0] pushSlot;
  logic [1:0]        pushWord;

  ksg_control #(.NUM_SLOTS(NUM_SLOTS)) uCtl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .selValue(selValue), .selPerm(selPerm), .stb(stb),
    .rspValid(regRspValid), .accErr(regAccErr), .pushSlot(pushSlot),
    .pushWord(pushWord), .pushBusy(pushBusy), .pushDone(pushDone), .pushErr(pushErr)
  );

  ksg_datapath #(.NUM_SLOTS(NUM_SLOTS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(regWData), .pushSlot(pushSlot),
    .pushWord(pushWord), .selValue(selValue), .selPerm(selPerm), .rdData(regRData),
    .secAddr(secAddr), .secData(secData)
  );

  assign secValid = pushBusy;

  // R6: a refused access never leaks data
  p_err_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRspValid && regAccErr) |-> regRData == 32'd0);
endmodule

// File: tb/tb_key_slot_gate.sv
module tb_key_slot_gate;
  localparam int N = 128;
  localparam int AW = 11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, regValid, regWrite;
  logic [AW-1:0] regAddr;
  logic [31:0] regWData;
  logic regRspValid, regAccErr, pushBusy, pushDone, pushErr, secValid;
  logic [31:0] regRData, secAddr, secData;

  key_slot_gate dut (.*);

  logic [31:0] mDest [N];
  logic [31:0] mPerm [N];
  logic [31:0] mKey  [N][4];
  int mSel;
  logic [63:0] beats [$];
  int vectors = 0, misses = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sa(int n, int w);
    return {1'b1, 7'(n), 3'(w)};
  endfunction
  function automatic logic [AW-1:0] ca(int w);
    return {1'b0, 7'd0, 3'(w)};
  endfunction

  task automatic step(string tag, bit v, bit w, logic [AW-1:0] a, logic [31:0] d);
    bit eRsp, eErr, eDone, ePErr, pushCmd, busyPre;
    logic [31:0] eRData;
    int n, w3, s;
    regValid = v; regWrite = w; regAddr = a; regWData = d;
    eRsp = v; eErr = 0; eRData = 0; eDone = 0; ePErr = 0; pushCmd = 0;
    busyPre = beats.size() > 0;
    if (v) begin
      w3 = int'(a[2:0]);
      if (!a[AW-1]) begin
        if (w) begin
          if (w3 == 0) mSel = int'(d[7:0]);
          else if (w3 == 1) pushCmd = 1;
        end else if (w3 == 0) eRData = 32'(mSel);
      end else begin
        n = int'(a[9:3]);
        if (mSel != n + 1 || w3 > 5) eErr = 1;
        else if (w3 == 0) begin
          if (w) mDest[n] = d; else eRData = mDest[n];
        end else if (w3 == 1) begin
          if (w) begin
            if (mPerm[n][31:16] == 16'hFFFF)
              mPerm[n][31:16] = {d[31:17], d[16] & mPerm[n][16]};
            if (mPerm[n][15:0] == 16'hFFFF) mPerm[n][15:0] = d[15:0];
          end else eRData = mPerm[n];
        end else begin
          if (w) begin
            if (mPerm[n][0]) mKey[n][w3-2] = d; else eErr = 1;
          end else if (mPerm[n][1] && mPerm[n][16]) eRData = mKey[n][w3-2];
          else eErr = 1;
        end
      end
    end
    if (busyPre) begin
      void'(beats.pop_front());
      if (beats.size() == 0) eDone = 1;
    end else if (pushCmd) begin
      s = mSel;
      if (s >= 1 && s <= N && mPerm[s-1][2] && mPerm[s-1][16]) begin
        for (int i = 0; i < 4; i++) beats.push_back({mDest[s-1] + 32'(4 * i), mKey[s-1][i]});
      end else begin
        eDone = 1; ePErr = 1;
      end
    end
    @(posedge clk); #1;
    chk(tag, "regRspValid", 32'(regRspValid), 32'(eRsp));
    if (eRsp) begin
      chk(tag, "regRData", regRData, eRData);
      chk(tag, "regAccErr", 32'(regAccErr), 32'(eErr));
    end
    chk(tag, "pushBusy", 32'(pushBusy), 32'(beats.size() > 0));
    chk(tag, "secValid", 32'(secValid), 32'(beats.size() > 0));
    if (beats.size() > 0) begin
      chk(tag, "secAddr", secAddr, beats[0][63:32]);
      chk(tag, "secData", secData, beats[0][31:0]);
    end
    chk(tag, "pushDone", 32'(pushDone), 32'(eDone));
    chk(tag, "pushErr", 32'(pushErr), 32'(ePErr));
    @(negedge clk);
    regValid = 0;
  endtask

  task automatic idle(string tag, int cnt);
    for (int i = 0; i < cnt; i++) step(tag, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mDest[i] = '1; mPerm[i] = '1;
      for (int k = 0; k < 4; k++) mKey[i][k] = '1;
    end
    mSel = 0;
    rstN = 0; regValid = 0; regWrite = 0; regAddr = '0; regWData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    idle("R1", 1);
    step("R1", 1, 0, ca(0), 0);
    step("R3", 1, 1, ca(0), 1);
    step("R1", 1, 0, sa(0, 0), 0);
    step("R1", 1, 0, sa(0, 1), 0);
    step("R1", 1, 0, sa(0, 2), 0);
    // R3: select gating
    step("R3", 1, 1, ca(0), 0);
    step("R3", 1, 0, sa(0, 0), 0);
    step("R3", 1, 1, sa(0, 0), 32'h1111_2222);
    step("R3", 1, 1, ca(0), 1);
    step("R8", 1, 1, sa(0, 0), 32'h4000_1000);
    step("R8", 1, 0, sa(0, 0), 0);
    step("R3", 1, 1, sa(5, 0), 32'h0000_1234);
    step("R3", 1, 1, ca(0), 6);
    step("R3", 1, 0, sa(5, 0), 0);
    step("R3", 1, 1, ca(0), 200);
    step("R3", 1, 0, sa(5, 0), 0);
    step("R10", 1, 1, ca(1), 0);
    // R7: key writes with write permission
    step("R3", 1, 1, ca(0), 1);
    for (int k = 0; k < 4; k++) step("R7", 1, 1, sa(0, 2 + k), 32'hA000_0000 + 32'(k * 17));
    for (int k = 0; k < 4; k++) step("R7", 1, 0, sa(0, 2 + k), 0);
    // R9: push sequence; R11: second command while busy
    step("R9", 1, 1, ca(1), 0);
    step("R9", 1, 0, sa(0, 0), 0);
    step("R11", 1, 1, ca(1), 0);
    idle("R9", 4);
    // R2: reserved words
    step("R2", 1, 0, sa(0, 6), 0);
    step("R2", 1, 0, sa(0, 7), 0);
    step("R2", 1, 0, ca(2), 0);
    step("R2", 1, 0, ca(0), 0);
    // R4: halfwise write-once
    step("R4", 1, 1, sa(0, 1), 32'hFFFF_FFFA);
    step("R4", 1, 0, sa(0, 1), 0);
    step("R4", 1, 1, sa(0, 1), 32'hFFFF_FFFF);
    step("R4", 1, 0, sa(0, 1), 0);
    // R7 refused write, R6 read allowed without push
    step("R7", 1, 1, sa(0, 2), 32'h0000_0055);
    step("R6", 1, 0, sa(0, 2), 0);
    step("R10", 1, 1, ca(1), 0);
    idle("R10", 1);
    // R5: revocation
    step("R5", 1, 1, sa(0, 1), 32'hFFFE_0000);
    step("R5", 1, 0, sa(0, 1), 0);
    step("R5", 1, 0, sa(0, 3), 0);
    step("R5", 1, 1, sa(0, 1), 32'hFFFF_FFFF);
    step("R5", 1, 0, sa(0, 1), 0);
    step("R5", 1, 1, ca(1), 0);
    idle("R5", 1);
    // R9: last slot
    step("R9", 1, 1, ca(0), 128);
    step("R9", 1, 1, sa(127, 0), 32'h5000_0FF0);
    for (int k = 0; k < 4; k++) step("R9", 1, 1, sa(127, 2 + k), 32'hC0DE_0000 + 32'(k));
    step("R9", 1, 1, ca(1), 0);
    idle("R9", 5);
    // R10: nothing selected
    step("R10", 1, 1, ca(0), 0);
    step("R10", 1, 1, ca(1), 0);
    idle("R10", 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule